// File: doc/BRIEF.md
# Pipelined ADC Digital Correction Back End

This block is the digital half of a multi-stage pipelined analog-to-digital converter. Every analog sample is resolved by a chain of sub-converter stages, and each stage reports a small code for it. The first stages also amplify their residue by eight. A 4-bit code from such a stage therefore carries three useful bits and one redundant bit, so a comparator decision that lands slightly wrong in one stage can be repaired by the next. Neighbouring stages run on opposite clock phases. As a result, the codes that belong to one sample reach the block spread over two clock periods, half a period apart.

The block delays every stage code so that all codes of one sample meet in the same cycle. Odd stages are first captured on the falling clock edge. It then adds the codes with weights that overlap by one bit, removes the mid-scale bias of the lower stages, and clamps the sum into the 12-bit output range. The result is registered as an offset-binary word with a valid flag. Stage count, code width, bits per stage and output width are parameters. The defaults are four stages of 4 bits, 3 effective bits per stage and a 12-bit word.

Top module: `adc_pipe_backend`

## Requirements
- R1: A synchronous active-high reset drives word_out to 0 and word_valid to 0. No stage code captured before or during reset ever produces an output word.
- R2: A sample's four codes are captured as follows. Stage 0 (stage_code[3:0]) is taken on rising edge P. Stage 1 (bits [7:4]) is taken on the next falling edge. Stage 2 (bits [11:8]) is taken on rising edge P+1. Stage 3 (bits [15:12]) is taken on the falling edge after that. The corrected word and word_valid=1 appear after rising edge P+3, and back-to-back samples give one word per clock.
- R3: If stage codes c0..c3 give V = 512·c0 + 64·(c1−4) + 8·(c2−4) + (c3−4), and V lies in 0..4095, then word_out equals V. The word is unsigned offset binary with bit 11 as the MSB.
- R4: When V is below zero, word_out is 0 (0x000) and never wraps.
- R5: When V is above 4095, word_out is 4095 (0xFFF) and never wraps.
- R6: A sample for which some but not all of its four stage valids were high produces word_valid=0 in its output cycle. In that cycle word_out keeps its previous value.
- R7: A sample whose four stage valids are all low has no effect on word_out, whatever its codes, and produces word_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock. Even stages are captured on the rising edge, odd stages on the falling edge. |
| rst | input | 1 | Synchronous reset, active high |
| stage_code | input | 16 | Stage k code in bits [4k+3:4k]. Stage 0 is the most significant stage. |
| stage_valid | input | 4 | Bit k qualifies the code of stage k |
| word_out | output | 12 | Corrected, clamped offset-binary sample |
| word_valid | output | 1 | High for one cycle per completed sample |

## Verification
The bench streams more than seven hundred samples without gaps and checks every output word against an arithmetic model at its exact cycle. A wrong delay on any one stage mixes codes from neighbouring samples, and a miscounted pipeline shifts the whole stream by a cycle, so either fault shows up as wrong words or a misplaced valid. The sweeps include the redundant code range and walk the lower stages across the bottom of the scale and just below the top. A clamp missing at either end would therefore show up as a wrapped value around 0 or 4095. Samples with one stage's valid removed, each stage in turn, and samples with all valids low but junk codes catch a design that fires on a partial sample or lets ignored codes disturb the held word. A reset applied during steady valid traffic must clear the output and bring the first word back exactly three clocks later.

// File: rtl/adc_pipe_pkg.sv
package adc_pipe_pkg;

   // Bit offset at which stage k is added into the sum (stage 0 highest).
   function automatic int stage_shift(input int step, input int n_stages, input int k);
      return step * (n_stages - 1 - k);
   endfunction

   // Rising edge (counted from stage 0 capture) at which all codes meet.
   function automatic int align_point(input int n_stages);
      return (n_stages - 1) / 2 + 1;
   endfunction

   // Rising-edge registers needed after capture for stage k.
   // Even stages are captured on a rising edge, odd stages on a falling one.
   function automatic int align_depth(input int n_stages, input int k);
      if ((k % 2) == 0)
         return align_point(n_stages) - (k / 2) + 1;
      else
         return align_point(n_stages) - ((k - 1) / 2);
   endfunction

   // Mid-scale offset removed from every stage below the first.
   function automatic int bias_total(input int step, input int n_stages);
      int acc;
      acc = 0;
      for (int k = 1; k < n_stages; k++)
         acc += (1 << (step - 1)) << stage_shift(step, n_stages, k);
      return acc;
   endfunction

endpackage

// File: rtl/adc_stage_align.sv
module adc_stage_align
   import adc_pipe_pkg::*;
#(
   parameter int CODE_W      = 4,
   parameter bit NEG_CAPTURE = 1'b0,
   parameter int DEPTH       = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CODE_W-1:0] in_code,
   input  logic              in_vld,
   output logic [CODE_W-1:0] out_code,
   output logic              out_vld
);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("adc_stage_align: DEPTH must be at least 1");
      end
      if (CODE_W < 2) begin : g_bad_width
         $error("adc_stage_align: CODE_W must be at least 2");
      end
   endgenerate

   logic [CODE_W-1:0] head_code;
   logic              head_vld;

   // Capture variant: odd stages settle half a period later and are
   // taken on the falling edge before joining the rising-edge chain.
   generate
      if (NEG_CAPTURE) begin : g_neg
         logic [CODE_W-1:0] neg_code;
         logic              neg_vld;
         always_ff @(negedge clk) begin
            if (rst) begin
               neg_code <= '0;
               neg_vld  <= 1'b0;
            end else begin
               neg_code <= in_code;
               neg_vld  <= in_vld;
            end
         end
         assign head_code = neg_code;
         assign head_vld  = neg_vld;
      end else begin : g_pos
         assign head_code = in_code;
         assign head_vld  = in_vld;
      end
   endgenerate

   logic [DEPTH-1:0][CODE_W-1:0] chain_code;
   logic [DEPTH-1:0]             chain_vld;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_code <= '0;
         chain_vld  <= '0;
      end else begin
         for (int j = 0; j < DEPTH; j++) begin
            if (j == 0) begin
               chain_vld[0] <= head_vld;
               if (head_vld)
                  chain_code[0] <= head_code;
            end else begin
               chain_vld[j]  <= chain_vld[j-1];
               chain_code[j] <= chain_code[j-1];
            end
         end
      end
   end

   assign out_code = chain_code[DEPTH-1];
   assign out_vld  = chain_vld[DEPTH-1];

   // R2: a qualified code leaves the delay line exactly DEPTH rising edges
   // after it entered the rising-edge chain.
   a_r2_align_depth: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> $past(head_vld, DEPTH))
      else $error("a_r2_align_depth: output valid without matching input");

endmodule

// File: rtl/adc_overlap_sum.sv
module adc_overlap_sum
   import adc_pipe_pkg::*;
#(
   parameter int N_STAGES = 4,
   parameter int CODE_W   = 4,
   parameter int STEP     = 3,
   parameter int SUM_W    = 15
) (
   input  logic [N_STAGES*CODE_W-1:0] codes,
   output logic signed [SUM_W-1:0]    sum
);

   localparam int MAX_MAG = CODE_W + STEP * (N_STAGES - 1);
   localparam logic [SUM_W-1:0] BIAS_V = SUM_W'(bias_total(STEP, N_STAGES));

   generate
      if (STEP >= CODE_W) begin : g_no_redundancy
         $error("adc_overlap_sum: STEP must leave at least one redundant bit");
      end
      if (SUM_W < MAX_MAG + 2) begin : g_narrow_sum
         $error("adc_overlap_sum: SUM_W too small for the weighted sum");
      end
   endgenerate

   // Running partial sums; element 0 starts at minus the total bias.
   logic [N_STAGES:0][SUM_W-1:0] part;

   assign part[0] = -BIAS_V;

   generate
      for (genvar k = 0; k < N_STAGES; k++) begin : g_term
         localparam int SHIFT = stage_shift(STEP, N_STAGES, k);
         logic [SUM_W-1:0] term;
         assign term        = SUM_W'(codes[k*CODE_W +: CODE_W]) << SHIFT;
         assign part[k+1]   = part[k] + term;
      end
   endgenerate

   assign sum = signed'(part[N_STAGES]);

endmodule

// File: rtl/adc_sat.sv
module adc_sat #(
   parameter int IN_W  = 15,
   parameter int OUT_W = 12
) (
   input  logic signed [IN_W-1:0] din,
   output logic [OUT_W-1:0]       dout
);

   generate
      if (IN_W < OUT_W + 1) begin : g_bad_width
         $error("adc_sat: IN_W must exceed OUT_W by at least one sign bit");
      end
   endgenerate

   logic above;

   // Variant: with no headroom bits between the sign and the output field,
   // a non-negative input can never exceed the range.
   generate
      if (IN_W > OUT_W + 1) begin : g_headroom
         assign above = |din[IN_W-2:OUT_W];
      end else begin : g_flush
         assign above = 1'b0;
      end
   endgenerate

   always_comb begin
      if (din[IN_W-1])
         dout = '0;
      else if (above)
         dout = '1;
      else
         dout = din[OUT_W-1:0];
   end

endmodule

// File: rtl/adc_pipe_backend.sv
module adc_pipe_backend
   import adc_pipe_pkg::*;
#(
   parameter int N_STAGES = 4,
   parameter int CODE_W   = 4,
   parameter int STEP     = 3,
   parameter int OUT_W    = 12
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [N_STAGES*CODE_W-1:0] stage_code,
   input  logic [N_STAGES-1:0]        stage_valid,
   output logic [OUT_W-1:0]           word_out,
   output logic                       word_valid
);

   localparam int SUM_W    = CODE_W + STEP * (N_STAGES - 1) + 2;
   localparam int ALIGN_AT = align_point(N_STAGES);
   localparam int LATENCY  = ALIGN_AT + 1;

   generate
      if (N_STAGES < 2 || N_STAGES > 8) begin : g_bad_stages
         $error("adc_pipe_backend: N_STAGES must be 2..8");
      end
      if (OUT_W != STEP * N_STAGES) begin : g_bad_out
         $error("adc_pipe_backend: OUT_W must equal STEP*N_STAGES");
      end
   endgenerate

   logic [N_STAGES*CODE_W-1:0] aligned_code;
   logic [N_STAGES-1:0]        aligned_vld;

   generate
      for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
         adc_stage_align #(
            .CODE_W      (CODE_W),
            .NEG_CAPTURE ((k % 2) == 1),
            .DEPTH       (align_depth(N_STAGES, k))
         ) u_align (
            .clk      (clk),
            .rst      (rst),
            .in_code  (stage_code[k*CODE_W +: CODE_W]),
            .in_vld   (stage_valid[k]),
            .out_code (aligned_code[k*CODE_W +: CODE_W]),
            .out_vld  (aligned_vld[k])
         );
      end
   endgenerate

   logic signed [SUM_W-1:0] raw_sum;
   logic [OUT_W-1:0]        clamped;

   adc_overlap_sum #(
      .N_STAGES (N_STAGES),
      .CODE_W   (CODE_W),
      .STEP     (STEP),
      .SUM_W    (SUM_W)
   ) u_sum (
      .codes (aligned_code),
      .sum   (raw_sum)
   );

   adc_sat #(
      .IN_W  (SUM_W),
      .OUT_W (OUT_W)
   ) u_sat (
      .din  (raw_sum),
      .dout (clamped)
   );

   logic complete;
   assign complete = &aligned_vld;

   // Output latch: update only on a fully qualified sample.
   always_ff @(posedge clk) begin
      if (rst) begin
         word_out   <= '0;
         word_valid <= 1'b0;
      end else begin
         word_valid <= complete;
         if (complete)
            word_out <= clamped;
      end
   end

   // R1: the cycle reset is released, the output is clear.
   a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!word_valid && word_out == '0))
      else $error("a_r1_reset_state: output not cleared by reset");

   // R6/R7: without a complete sample the word is held.
   a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
      !word_valid |-> $stable(word_out))
      else $error("a_r7_hold_idle: word changed without a valid sample");

   // R6: an output word implies the rising-edge stages of that sample were
   // qualified, LATENCY+1-k/2 edges back for even stage k.
   generate
      for (genvar k = 0; k < N_STAGES; k += 2) begin : g_chk
         a_r6_stage_qualified: assert property (@(posedge clk) disable iff (rst)
            word_valid |-> $past(stage_valid[k], LATENCY + 1 - k / 2))
            else $error("a_r6_stage_qualified: word from unqualified stage %0d", k);
      end
   endgenerate

endmodule

// File: tb/sim_adc_pipe_backend.sv
module sim_adc_pipe_backend;

   localparam int CLK_PERIOD = 10;
   localparam int NS         = 784;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  bc [4];
   logic [3:0]  bv;
   logic [15:0] stage_code;
   logic [11:0] word_out;
   logic        word_valid;

   assign stage_code = {bc[3], bc[2], bc[1], bc[0]};

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_pipe_backend u0 (
      .clk         (clk),
      .rst         (rst),
      .stage_code  (stage_code),
      .stage_valid (bv),
      .word_out    (word_out),
      .word_valid  (word_valid)
   );

   int n_chk  = 0;
   int n_pass = 0;
   int cyc    = 0;
   int base   = 0;
   int last_exp = 0;
   bit mon_on = 1'b0;

   int cd [NS][4];
   bit vd [NS][4];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int got, input int exp);
      n_chk++;
      if (ok) n_pass++;
      else $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, got, exp, cyc);
   endtask

   function automatic int raw_of(input int s);
      return 512*cd[s][0] + 64*(cd[s][1]-4) + 8*(cd[s][2]-4) + (cd[s][3]-4);
   endfunction

   function automatic int clamp_of(input int r);
      if (r < 0) return 0;
      if (r > 4095) return 4095;
      return r;
   endfunction

   function automatic bit all_v(input int s);
      return vd[s][0] && vd[s][1] && vd[s][2] && vd[s][3];
   endfunction

   function automatic bit any_v(input int s);
      return vd[s][0] || vd[s][1] || vd[s][2] || vd[s][3];
   endfunction

   // Output monitor: one check per falling edge while streaming.
   always @(negedge clk) begin
      int s;
      int r;
      if (mon_on) begin
         s = cyc - base - 3;
         if (s >= 0 && s < NS && all_v(s)) begin
            r = raw_of(s);
            chk(word_valid == 1'b1, "R2 valid at latency 3", int'(word_valid), 1);
            if (r < 0)
               chk(word_out == 12'd0, "R4 low clamp", int'(word_out), 0);
            else if (r > 4095)
               chk(word_out == 12'hFFF, "R5 high clamp", int'(word_out), 4095);
            else
               chk(int'(word_out) == r, "R3 weighted sum", int'(word_out), r);
            last_exp = clamp_of(r);
         end else if (s >= 0 && s < NS) begin
            if (any_v(s))
               chk(!word_valid && int'(word_out) == last_exp, "R6 partial sample",
                   int'(word_out), last_exp);
            else
               chk(!word_valid && int'(word_out) == last_exp, "R7 idle codes ignored",
                   int'(word_out), last_exp);
         end else begin
            chk(!word_valid && int'(word_out) == last_exp, "R2 no word outside stream",
                int'(word_out), last_exp);
         end
      end
   end

   function automatic int code_at(input int s, input int k);
      if (s < 0 || s >= NS) return 0;
      return cd[s][k];
   endfunction

   function automatic bit vld_at(input int s, input int k);
      if (s < 0 || s >= NS) return 1'b0;
      return vd[s][k];
   endfunction

   initial begin
      // Sweep A: top two stages exhaustive, lower stages varied.
      for (int s = 0; s < 256; s++) begin
         cd[s][0] = s >> 4;
         cd[s][1] = s & 15;
         cd[s][2] = (s * 7) & 15;
         cd[s][3] = (s * 3 + 5) & 15;
         for (int k = 0; k < 4; k++) vd[s][k] = 1'b1;
      end
      // Sweep B: lower stages exhaustive near zero and near full scale.
      for (int i = 0; i < 512; i++) begin
         int s = 256 + i;
         cd[s][0] = (i < 256) ? 0 : 7;
         cd[s][1] = (i < 256) ? 4 : 11;
         cd[s][2] = (i >> 4) & 15;
         cd[s][3] = i & 15;
         for (int k = 0; k < 4; k++) vd[s][k] = 1'b1;
      end
      // Qualifier patterns: one stage dropped in turn, or all stages idle.
      for (int i = 0; i < 16; i++) begin
         int s = 768 + i;
         cd[s][0] = i % 8;
         cd[s][1] = 5;
         cd[s][2] = 6;
         cd[s][3] = (i * 5) % 16;
         for (int k = 0; k < 4; k++) vd[s][k] = 1'b1;
         if (i % 4 == 1) vd[s][i/4] = 1'b0;
         if (i % 4 == 3) begin
            for (int k = 0; k < 4; k++) begin
               vd[s][k] = 1'b0;
               cd[s][k] = 15;
            end
         end
      end

      // R1: reset with live, valid junk on every stage.
      for (int k = 0; k < 4; k++) bc[k] = 4'd9;
      bv = 4'b1111;
      rst = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(!word_valid && word_out == 12'd0, "R1 reset clears output", int'(word_out), 0);
      @(posedge clk); #1;
      rst = 1'b0;
      bv  = 4'b0000;

      // Continuous stream: even stages driven after the falling edge,
      // odd stages after the rising edge, each half a period apart.
      for (int s = 0; s < NS + 2; s++) begin
         @(negedge clk); #1;
         if (s == 0) begin
            base   = cyc + 1;
            mon_on = 1'b1;
         end
         bc[0] = 4'(code_at(s, 0));     bv[0] = vld_at(s, 0);
         bc[2] = 4'(code_at(s - 1, 2)); bv[2] = vld_at(s - 1, 2);
         @(posedge clk); #1;
         bc[1] = 4'(code_at(s, 1));     bv[1] = vld_at(s, 1);
         bc[3] = 4'(code_at(s - 1, 3)); bv[3] = vld_at(s - 1, 3);
      end
      repeat (5) @(negedge clk);
      #1 mon_on = 1'b0;

      // Steady full-scale overflow, then a reset in the middle of traffic.
      for (int k = 0; k < 4; k++) bc[k] = 4'd15;
      bv = 4'b1111;
      repeat (5) @(negedge clk);
      chk(word_valid && word_out == 12'hFFF, "R5 steady overflow clamps", int'(word_out), 4095);
      @(posedge clk); #1 rst = 1'b1;
      @(posedge clk); #1;
      @(negedge clk);
      chk(!word_valid && word_out == 12'd0, "R1 reset during traffic", int'(word_out), 0);
      @(posedge clk); #1 rst = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(!word_valid, "R2 no word before pipeline fills", int'(word_valid), 0);
      end
      @(negedge clk);
      chk(word_valid && word_out == 12'hFFF, "R2 first word three clocks after first sample",
          int'(word_out), 4095);

      $display("%0d/%0d checks passed", n_pass, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++;
      $display("FAIL watchdog: run did not complete, got %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_pass, n_chk);
      $finish;
   end

endmodule